// File: doc/BRIEF.md
# Dual-Bank SDRAM Command Decoder

This block sits at the command input of a two-bank synchronous DRAM model or controller. On every rising clock edge it samples the chip select, the three command strobes and a 12-bit address. It decodes one of eight commands and checks that command against the state of the two banks and the mode register. An accepted command is reported one cycle later as a one-hot strobe. A rejected command raises an illegal flag and changes nothing.

Each bank runs its own three-state machine. In BANK_IDLE the bank is precharged. An accepted activate moves it to BANK_OPEN. A read or write that asks for auto-precharge moves BANK_OPEN to BANK_CLOSING. A precharge takes BANK_OPEN or BANK_CLOSING back to BANK_IDLE. An end-of-burst pulse for that bank takes BANK_CLOSING back to BANK_IDLE. The mode register has two states. It starts in MODE_UNSET and moves to MODE_SET on the first accepted mode write. No activate is accepted until MODE_SET is reached. Address bit 11 picks the bank. Address bit 10 has two uses: on a read or write it asks for auto-precharge, and on a precharge it widens the precharge to both banks.

All outputs are registered. A command sampled at edge k is visible at the outputs just after edge k.

Top module: `sdram_dual_bank_ctl`

## Requirements
- R1: While cs_n is high, no strobe fires, illegal stays low and the bank and mode state are unchanged, whatever the command lines carry. An end-of-burst pulse still closes a bank that is in BANK_CLOSING.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows, and an accepted command sets exactly one bit of cmd_strobe:
  - 111 is no-op, bit 0.
  - 011 is activate, bit 1.
  - 101 is read, bit 2.
  - 100 is write, bit 3.
  - 010 is precharge, bit 4.
  - 110 is burst stop, bit 5.
  - 001 is refresh, bit 6.
  - 000 is mode write, bit 7.
- R3: An activate is accepted when the addressed bank (addr[11]: 0 is bank A, 1 is bank B) is idle and the mode register is set. The bank opens, and addr[10:0] is latched as that bank's row.
- R4: An activate is rejected, with illegal raised, no strobe and the row unchanged, in two cases: the addressed bank is open or closing, or no mode write has been accepted since reset.
- R5: A read or write is rejected, with illegal raised and no state change, if the addressed bank is idle or in BANK_CLOSING.
- R6: An accepted read or write with addr[10]=1 puts the bank in BANK_CLOSING. The bank then closes at the edge where its burst_end bit is sampled high. With addr[10]=0 the bank stays open, and burst_end has no effect on it.
- R7: A precharge is always accepted. With addr[10]=1 it closes both banks. With addr[10]=0 it closes only the bank named by addr[11]. A precharge to an idle bank leaves that bank idle.
- R8: A mode write with both banks idle and supported fields is accepted and latches the fields:
  - addr[2:0] is the burst length code, 0 to 3.
  - addr[3] is the interleaved wrap.
  - addr[6:4] is the CAS latency, 2 or 3.
  - A later mode write replaces the fields.
- R9: A mode write is rejected, with illegal raised and the fields unchanged, in two cases: either bank is open, or the burst length code has bit 2 set or the CAS latency is not 2 or 3.
- R10: After reset both banks are idle, the strobes and illegal are low, the mode register is unset and every latched field and row reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low enables decoding |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| addr | input | 12 | Bit 11 bank, bit 10 auto/all precharge, bits 10:0 row, bits 6:0 mode fields |
| burst_end | input | 2 | Per-bank end-of-burst pulse (bit 0 bank A) |
| cmd_strobe | output | 8 | One-hot accepted command, bit map per R2 |
| illegal | output | 1 | Command sampled last edge was rejected |
| bank_open | output | 2 | Bank is open or closing (bit 0 bank A) |
| row_a | output | 11 | Latched row of bank A |
| row_b | output | 11 | Latched row of bank B |
| mode_valid | output | 1 | A mode write has been accepted |
| burst_len | output | 3 | Latched burst length code |
| wrap_ilv | output | 1 | Latched interleaved wrap bit |
| cas_lat | output | 3 | Latched CAS latency |

## Verification
A bank that is stuck in the wrong state shows up at the very next command to it. If a bank is wrongly open, an activate to it raises illegal. If a bank is wrongly idle, a read to it raises illegal. Either symptom appears one edge after that command, and bank_open shows the error at once.

A lost auto-precharge mark shows up one edge after the burst_end pulse: bank_open stays high when it should have dropped. A mode register that takes writes when it should not shows up in cas_lat one edge after the rejected write.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    localparam int NUM_CMDS = 8;

    // enum value doubles as the strobe bit index
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BANK_IDLE,
        BANK_OPEN,
        BANK_CLOSING
    } bank_st_e;

    typedef enum logic {
        MODE_UNSET,
        MODE_SET
    } mode_st_e;

    // supported: burst code 0..3, CAS latency 2 or 3
    function automatic logic mode_fields_ok(input logic [6:0] f);
        return !f[2] && ((f[6:4] == 3'd2) || (f[6:4] == 3'd3));
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic cmd_valid,
    output cmd_e cmd
);

    always_comb begin
        cmd_valid = !cs_n;
        unique case ({ras_n, cas_n, we_n})
            3'b111: cmd = CMD_NOP;
            3'b011: cmd = CMD_ACT;
            3'b101: cmd = CMD_RD;
            3'b100: cmd = CMD_WR;
            3'b010: cmd = CMD_PRE;
            3'b110: cmd = CMD_BST;
            3'b001: cmd = CMD_REF;
            3'b000: cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rw_go,
    input  logic             ap_req,
    input  logic             pre_go,
    input  logic             burst_end,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_idle,
    output logic             is_ready,
    output logic [ROW_W-1:0] row_q
);

    bank_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BANK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BANK_IDLE:    if (act_go) st_d = BANK_OPEN;
            BANK_OPEN: begin
                if (pre_go)                st_d = BANK_IDLE;
                else if (rw_go && ap_req)  st_d = BANK_CLOSING;
            end
            BANK_CLOSING: if (pre_go || burst_end) st_d = BANK_IDLE;
            default:      st_d = BANK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      row_q <= '0;
        else if (act_go) row_q <= row_in;
    end

    assign is_idle  = (st_q == BANK_IDLE);
    assign is_ready = (st_q == BANK_OPEN);

    // R6: a pending auto-precharge finishes on the end-of-burst pulse
    a_r6_ap_close: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BANK_CLOSING && burst_end) |=> (st_q == BANK_IDLE));

    // R3: an activate leaves the bank open with the new row
    a_r3_act_row: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> (!is_idle && row_q == $past(row_in)));

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_go,
    input  logic [6:0] field_in,
    output logic       mode_valid,
    output logic [2:0] burst_len,
    output logic       wrap_ilv,
    output logic [2:0] cas_lat
);

    mode_st_e   st_q, st_d;
    logic [6:0] field_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MODE_UNSET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MODE_UNSET: if (wr_go) st_d = MODE_SET;
            MODE_SET:   st_d = MODE_SET;
            default:    st_d = MODE_UNSET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     field_q <= '0;
        else if (wr_go) field_q <= field_in;
    end

    assign mode_valid = (st_q == MODE_SET);
    assign burst_len  = field_q[2:0];
    assign wrap_ilv   = field_q[3];
    assign cas_lat    = field_q[6:4];

    // R8: an accepted write is visible at the next edge
    a_r8_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (mode_valid && {cas_lat, wrap_ilv, burst_len} == $past(field_in)));

endmodule

// File: rtl/sdram_dual_bank_ctl.sv
module sdram_dual_bank_ctl
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          burst_end,
    output logic [NUM_CMDS-1:0] cmd_strobe,
    output logic                illegal,
    output logic [1:0]          bank_open,
    output logic [ADDR_W-2:0]   row_a,
    output logic [ADDR_W-2:0]   row_b,
    output logic                mode_valid,
    output logic [2:0]          burst_len,
    output logic                wrap_ilv,
    output logic [2:0]          cas_lat
);

    localparam int ROW_W    = ADDR_W - 1;
    localparam int BANK_BIT = ADDR_W - 1;
    localparam int AP_BIT   = ADDR_W - 2;

    logic       cmd_valid;
    cmd_e       cmd;
    logic       bsel, ap, ok, legal_go, bad_go;
    logic [1:0] bank_idle, bank_ready, act_go, rw_go, pre_go;
    logic [ROW_W-1:0] rows [2];

    sdram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd_valid(cmd_valid), .cmd(cmd)
    );

    assign bsel = addr[BANK_BIT];
    assign ap   = addr[AP_BIT];

    always_comb begin
        unique case (cmd)
            CMD_ACT:        ok = bank_idle[bsel] && mode_valid;
            CMD_RD, CMD_WR: ok = bank_ready[bsel];
            CMD_MRS:        ok = (&bank_idle) && mode_fields_ok(addr[6:0]);
            default:        ok = 1'b1;
        endcase
        legal_go = cmd_valid && ok;
        bad_go   = cmd_valid && !ok;
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        assign act_go[g] = legal_go && (cmd == CMD_ACT) && (bsel == g[0]);
        assign rw_go[g]  = legal_go && (cmd == CMD_RD || cmd == CMD_WR) && (bsel == g[0]);
        assign pre_go[g] = legal_go && (cmd == CMD_PRE) && (ap || bsel == g[0]);

        sdram_bank_fsm #(.ROW_W(ROW_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_go(act_go[g]), .rw_go(rw_go[g]), .ap_req(ap),
            .pre_go(pre_go[g]), .burst_end(burst_end[g]),
            .row_in(addr[ROW_W-1:0]),
            .is_idle(bank_idle[g]), .is_ready(bank_ready[g]),
            .row_q(rows[g])
        );
    end

    sdram_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n),
        .wr_go(legal_go && cmd == CMD_MRS),
        .field_in(addr[6:0]),
        .mode_valid(mode_valid), .burst_len(burst_len),
        .wrap_ilv(wrap_ilv), .cas_lat(cas_lat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= '0;
            illegal    <= 1'b0;
        end else begin
            cmd_strobe <= legal_go ? (NUM_CMDS'(1) << cmd) : '0;
            illegal    <= bad_go;
        end
    end

    assign bank_open = ~bank_idle;
    assign row_a     = rows[0];
    assign row_b     = rows[1];

    // R1: deselected cycles produce nothing
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_strobe == '0 && !illegal));

    // R2: at most one strobe, never together with illegal
    a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe) && !(illegal && |cmd_strobe));

    // R4: activate to a bank that is not idle is rejected
    a_r4_act_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && {ras_n, cas_n, we_n} == 3'b011 && bank_open[bsel]) |=> illegal);

    // R5: column access to an idle bank is rejected
    a_r5_rw_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && !cas_n && !bank_open[bsel]) |=> illegal);

    // R7: precharge with bit 10 set empties both banks
    a_r7_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && {ras_n, cas_n, we_n} == 3'b010 && ap) |=> (bank_open == 2'b00));

    // R9: mode write while a bank is open leaves the fields alone
    a_r9_mrs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && {ras_n, cas_n, we_n} == 3'b000 && |bank_open)
        |=> (illegal && $stable(cas_lat) && $stable(burst_len)));

endmodule

// File: tb/sdram_dual_bank_ctl_bench.sv
module sdram_dual_bank_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [1:0]  burst_end = '0;
    logic [7:0]  cmd_strobe;
    logic        illegal;
    logic [1:0]  bank_open;
    logic [10:0] row_a, row_b;
    logic        mode_valid;
    logic [2:0]  burst_len;
    logic        wrap_ilv;
    logic [2:0]  cas_lat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdram_dual_bank_ctl u_sdram_dual_bank_ctl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .burst_end(burst_end),
        .cmd_strobe(cmd_strobe), .illegal(illegal), .bank_open(bank_open),
        .row_a(row_a), .row_b(row_b), .mode_valid(mode_valid),
        .burst_len(burst_len), .wrap_ilv(wrap_ilv), .cas_lat(cas_lat)
    );

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                           C_WR  = 4'b0100, C_PRE = 4'b0010, C_BST = 4'b0110,
                           C_REF = 4'b0001, C_MRS = 4'b0000, C_DES = 4'b1111,
                           C_DACT = 4'b1011;
    localparam logic [7:0] S_NOP = 8'h01, S_ACT = 8'h02, S_RD = 8'h04, S_WR = 8'h08,
                           S_PRE = 8'h10, S_BST = 8'h20, S_REF = 8'h40, S_MRS = 8'h80,
                           S_NONE = 8'h00;

    // [35:32] req, [31:28] cmd, [27:16] addr, [15:14] burst_end,
    // [13:6] strobe, [5] illegal, [4:3] bank_open, [2:0] cas_lat
    localparam int NV = 24;
    localparam logic [35:0] VEC [NV] = '{
        {4'd4,  C_ACT,  12'h000, 2'b00, S_NONE, 1'b1, 2'b00, 3'd0}, // R4 before mode set
        {4'd8,  C_MRS,  12'h032, 2'b00, S_MRS,  1'b0, 2'b00, 3'd3}, // R8
        {4'd9,  C_MRS,  12'h012, 2'b00, S_NONE, 1'b1, 2'b00, 3'd3}, // R9 bad latency
        {4'd3,  C_ACT,  12'h155, 2'b00, S_ACT,  1'b0, 2'b01, 3'd3}, // R3 bank A
        {4'd4,  C_ACT,  12'h0AA, 2'b00, S_NONE, 1'b1, 2'b01, 3'd3}, // R4 already open
        {4'd3,  C_ACT,  12'hAAB, 2'b00, S_ACT,  1'b0, 2'b11, 3'd3}, // R3 bank B
        {4'd9,  C_MRS,  12'h020, 2'b00, S_NONE, 1'b1, 2'b11, 3'd3}, // R9 banks open
        {4'd2,  C_RD,   12'h800, 2'b00, S_RD,   1'b0, 2'b11, 3'd3}, // R2 read B
        {4'd6,  C_NOP,  12'h000, 2'b10, S_NOP,  1'b0, 2'b11, 3'd3}, // R6 no AP, ignored
        {4'd6,  C_WR,   12'h400, 2'b00, S_WR,   1'b0, 2'b11, 3'd3}, // R6 write A with AP
        {4'd5,  C_RD,   12'h000, 2'b00, S_NONE, 1'b1, 2'b11, 3'd3}, // R5 bank closing
        {4'd1,  C_DES,  12'h000, 2'b01, S_NONE, 1'b0, 2'b10, 3'd3}, // R1 burst end still closes
        {4'd5,  C_RD,   12'h000, 2'b00, S_NONE, 1'b1, 2'b10, 3'd3}, // R5 closed bank
        {4'd1,  C_DACT, 12'h000, 2'b00, S_NONE, 1'b0, 2'b10, 3'd3}, // R1 deselected activate
        {4'd2,  C_BST,  12'h000, 2'b00, S_BST,  1'b0, 2'b10, 3'd3}, // R2
        {4'd2,  C_REF,  12'h000, 2'b00, S_REF,  1'b0, 2'b10, 3'd3}, // R2
        {4'd7,  C_PRE,  12'h800, 2'b00, S_PRE,  1'b0, 2'b00, 3'd3}, // R7 single bank B
        {4'd7,  C_PRE,  12'h000, 2'b00, S_PRE,  1'b0, 2'b00, 3'd3}, // R7 idle bank
        {4'd3,  C_ACT,  12'h011, 2'b00, S_ACT,  1'b0, 2'b01, 3'd3}, // R3
        {4'd3,  C_ACT,  12'h822, 2'b00, S_ACT,  1'b0, 2'b11, 3'd3}, // R3
        {4'd7,  C_PRE,  12'h400, 2'b00, S_PRE,  1'b0, 2'b00, 3'd3}, // R7 all banks
        {4'd8,  C_MRS,  12'h020, 2'b00, S_MRS,  1'b0, 2'b00, 3'd2}, // R8 rewrite
        {4'd9,  C_MRS,  12'h024, 2'b00, S_NONE, 1'b1, 2'b00, 3'd2}, // R9 bad burst code
        {4'd5,  C_WR,   12'h800, 2'b00, S_NONE, 1'b1, 2'b00, 3'd2}  // R5 write closed B
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [11:0] a, input logic [1:0] be);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        addr      = a;
        burst_end = be;
        @(posedge clk);
        #1;
        {cs_n, ras_n, cas_n, we_n} = C_DES;
        burst_end = 2'b00;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check(10, 32'(cmd_strobe), 32'h0, "strobe at reset");
        check(10, 32'(bank_open), 32'h0, "banks at reset");
        check(10, 32'({mode_valid, cas_lat, burst_len, row_a, row_b}), 32'h0, "fields at reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][31:28], VEC[i][27:16], VEC[i][15:14]);
            check(int'(VEC[i][35:32]), 32'(cmd_strobe), 32'(VEC[i][13:6]), $sformatf("vec %0d strobe", i));
            check(int'(VEC[i][35:32]), 32'(illegal), 32'(VEC[i][5]), $sformatf("vec %0d illegal", i));
            check(int'(VEC[i][35:32]), 32'(bank_open), 32'(VEC[i][4:3]), $sformatf("vec %0d banks", i));
            check(int'(VEC[i][35:32]), 32'(cas_lat), 32'(VEC[i][2:0]), $sformatf("vec %0d cas", i));
        end
        // R3 rows from the last activates
        check(3, 32'(row_a), 32'h011, "row A");
        check(3, 32'(row_b), 32'h022, "row B");

        // R4 rejected activate keeps the row
        issue(C_ACT, 12'h300, 2'b00);
        issue(C_ACT, 12'h0FF, 2'b00);
        check(4, 32'(illegal), 32'h1, "second activate illegal");
        check(4, 32'(row_a), 32'h300, "row kept");

        // R8 full field latch with interleave
        issue(C_PRE, 12'h400, 2'b00);
        issue(C_MRS, 12'h03B, 2'b00);
        check(8, 32'({burst_len, wrap_ilv, cas_lat}), 32'({3'd3, 1'b1, 3'd3}), "mode fields");

        // R10 reset mid-run
        issue(C_ACT, 12'h812, 2'b00);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(10, 32'(bank_open), 32'h0, "banks after reset");
        check(10, 32'({mode_valid, illegal, cmd_strobe}), 32'h0, "mode/strobe after reset");
        check(10, 32'(row_b), 32'h0, "row after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule